// File: doc/BRIEF.md
# Memory Access Address Error Checker

This block sits between a 32-bit processor core and its bus. It inspects every access request before the request is issued, and it decides whether the access is an address error. For each request it looks at the address, the kind of access, the size of the access, the low bits of the vector base register and the single-chip operating-mode input. A parameterised map sorts the address into one of several regions: on-chip memory, external memory, the peripheral window, or a narrow 8-bit peripheral sub-range inside that window. Several rules can match the same request. When that happens, a fixed priority chooses one cause code.

The result is registered. A request presented with `req_valid` high at one clock edge produces `rpt_valid`, `rpt_error` and `rpt_cause`, and these hold for the whole following cycle. A small state machine carries the result. Its states are `ST_IDLE` (no request was presented in the previous cycle), `ST_PASS` (the previous request was clean) and `ST_FAULT` (the previous request broke a rule). Every state moves on every clock:

- to `ST_FAULT` on a valid request that breaks a rule;
- to `ST_PASS` on a valid request that breaks no rule;
- to `ST_IDLE` when no request is presented.

Reset forces `ST_IDLE`.

Input encodings:

- `req_kind`: 0 instruction fetch, 1 data read, 2 data write, 3 stack access, 4 vector-table access. Codes 5 to 7 are handled as a data read.
- `req_size`: 0 byte, 1 word, 2 longword. Code 3 is handled as a byte.

The default map is:

| Region | Address range |
|---|---|
| On-chip memory | 0x0000_0000 to 0x000F_FFFF |
| External memory | 0x0010_0000 to 0xFFFF_7FFF |
| Peripheral window | 0xFFFF_8000 to 0xFFFF_FFFF |
| 8-bit peripheral sub-range | 0xFFFF_8000 to 0xFFFF_83FF |

Top module: `addr_err_checker`

## Requirements
- R1: An instruction fetch (kind 0) with address bit 0 set reports cause 4 (odd fetch), unless a higher-priority cause applies.
- R2: An instruction fetch whose address lies in the peripheral window reports cause 2 (fetch from peripheral space). Data accesses of byte or word size to that window are not errors.
- R3: With `single_chip` high, any access of any kind to the external region reports cause 1 (mode violation). With `single_chip` low, the same access is not an error on that account.
- R4: A word (size 1) data read or write with address bit 0 set reports cause 5 (data misalignment).
- R5: A longword (size 2) data read or write whose address bits [1:0] are not 00 reports cause 5.
- R6: A longword data access, a stack access or a vector-table access that falls in the 8-bit peripheral sub-range reports cause 3 (wide access to narrow space), even when the address is aligned.
- R7: A stack access (kind 3) whose address bits [1:0] are not 00 reports cause 6 (stack misalignment).
- R8: A vector-table access (kind 4) made while `vbr` bits [1:0] are not 00 reports cause 7 (vector base misalignment).
- R9: Byte data accesses never report an alignment cause, whatever the address.
- R10: When several rules match, the cause reported is the one with the lowest cause code. Mode (1) comes before region (2, 3), and region comes before alignment (4 to 7).
- R11: A request with `req_valid` high at a clock edge sets `rpt_valid` to 1 during the next cycle. In that cycle `rpt_error` is 1 exactly when the cause is non-zero. A cycle with no request gives `rpt_valid`=0, `rpt_error`=0 and `rpt_cause`=0 in the cycle after it.
- R12: While reset is asserted, and in the first cycle after it, `rpt_valid`, `rpt_error` and `rpt_cause` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Access address |
| req_kind | input | 3 | Access kind code |
| req_size | input | 2 | Access size code |
| vbr | input | 32 | Vector base register value |
| single_chip | input | 1 | Single-chip operating mode |
| rpt_valid | output | 1 | Registered result is valid |
| rpt_error | output | 1 | Registered address error flag |
| rpt_cause | output | 3 | Registered cause code, 0 when clean |

## Verification
A region or mode violation and a misalignment can both be true for the same request. Examples are an odd fetch into the external region in single-chip mode, and a misaligned longword read inside the 8-bit peripheral sub-range. The table drives such overlapping requests deliberately. It judges them by comparing the single cause reported with the lowest-numbered cause that applies. The result state machine can also go from `ST_FAULT` straight to `ST_PASS` on back-to-back requests. The bench checks that case so that a stale cause does not linger.

// File: rtl/aec_pkg.sv
package aec_pkg;

    localparam logic [2:0] KIND_FETCH  = 3'd0;
    localparam logic [2:0] KIND_READ   = 3'd1;
    localparam logic [2:0] KIND_WRITE  = 3'd2;
    localparam logic [2:0] KIND_STACK  = 3'd3;
    localparam logic [2:0] KIND_VECTOR = 3'd4;

    localparam logic [1:0] SIZE_BYTE = 2'd0;
    localparam logic [1:0] SIZE_WORD = 2'd1;
    localparam logic [1:0] SIZE_LONG = 2'd2;

    typedef enum logic [2:0] {
        CAUSE_NONE         = 3'd0,
        CAUSE_MODE_EXT     = 3'd1,
        CAUSE_FETCH_PERIPH = 3'd2,
        CAUSE_NARROW_LONG  = 3'd3,
        CAUSE_FETCH_ODD    = 3'd4,
        CAUSE_DATA_ALIGN   = 3'd5,
        CAUSE_STACK_ALIGN  = 3'd6,
        CAUSE_VBR_ALIGN    = 3'd7
    } fault_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_FAULT = 2'd2
    } rpt_state_e;

    typedef struct packed {
        logic ext;
        logic periph;
        logic narrow;
    } region_hit_t;

endpackage

// File: rtl/aec_region_decode.sv
module aec_region_decode
    import aec_pkg::*;
#(
    parameter int unsigned        ADDR_W       = 32,
    parameter logic [ADDR_W-1:0]  EXT_BASE     = 'h0010_0000,
    parameter logic [ADDR_W-1:0]  EXT_LIMIT    = 'hFFFF_7FFF,
    parameter logic [ADDR_W-1:0]  PERIPH_BASE  = 'hFFFF_8000,
    parameter logic [ADDR_W-1:0]  PERIPH_LIMIT = 'hFFFF_FFFF,
    parameter bit                 NARROW_EN    = 1'b1,
    parameter logic [ADDR_W-1:0]  NARROW_BASE  = 'hFFFF_8000,
    parameter logic [ADDR_W-1:0]  NARROW_LIMIT = 'hFFFF_83FF
) (
    input  logic [ADDR_W-1:0] addr,
    output region_hit_t       hit
);

    logic in_ext;
    logic in_periph;
    logic in_narrow;

    always_comb begin
        in_ext    = (addr >= EXT_BASE) && (addr <= EXT_LIMIT);
        in_periph = (addr >= PERIPH_BASE) && (addr <= PERIPH_LIMIT);
    end

    // The narrow sub-range only counts inside the peripheral window.
    generate
        if (NARROW_EN) begin : g_narrow
            always_comb begin
                in_narrow = in_periph
                          && (addr >= NARROW_BASE)
                          && (addr <= NARROW_LIMIT);
            end
        end else begin : g_no_narrow
            always_comb begin
                in_narrow = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        hit.ext    = in_ext;
        hit.periph = in_periph;
        hit.narrow = in_narrow;
    end

endmodule

// File: rtl/aec_rule_eval.sv
module aec_rule_eval
    import aec_pkg::*;
(
    input  region_hit_t  hit,
    input  logic [1:0]   addr_lo,
    input  logic [2:0]   kind,
    input  logic [1:0]   size,
    input  logic [1:0]   vbr_lo,
    input  logic         single_chip,
    output fault_cause_e cause
);

    logic is_fetch;
    logic is_stack;
    logic is_vector;
    logic is_data;
    logic data_word;
    logic data_long;
    logic wide_access;

    logic v_mode;
    logic v_fetch_periph;
    logic v_narrow_long;
    logic v_fetch_odd;
    logic v_data_align;
    logic v_stack_align;
    logic v_vbr_align;

    always_comb begin
        is_fetch    = (kind == KIND_FETCH);
        is_stack    = (kind == KIND_STACK);
        is_vector   = (kind == KIND_VECTOR);
        is_data     = !is_fetch && !is_stack && !is_vector;
        data_word   = is_data && (size == SIZE_WORD);
        data_long   = is_data && (size == SIZE_LONG);
        wide_access = data_long || is_stack || is_vector;
    end

    always_comb begin
        v_mode         = single_chip && hit.ext;
        v_fetch_periph = is_fetch && hit.periph;
        v_narrow_long  = wide_access && hit.narrow;
        v_fetch_odd    = is_fetch && addr_lo[0];
        v_data_align   = (data_word && addr_lo[0])
                       || (data_long && (addr_lo != 2'b00));
        v_stack_align  = is_stack && (addr_lo != 2'b00);
        v_vbr_align    = is_vector && (vbr_lo != 2'b00);
    end

    // Fixed priority: mode, then region, then alignment.
    always_comb begin
        if (v_mode)              cause = CAUSE_MODE_EXT;
        else if (v_fetch_periph) cause = CAUSE_FETCH_PERIPH;
        else if (v_narrow_long)  cause = CAUSE_NARROW_LONG;
        else if (v_fetch_odd)    cause = CAUSE_FETCH_ODD;
        else if (v_data_align)   cause = CAUSE_DATA_ALIGN;
        else if (v_stack_align)  cause = CAUSE_STACK_ALIGN;
        else if (v_vbr_align)    cause = CAUSE_VBR_ALIGN;
        else                     cause = CAUSE_NONE;
    end

endmodule

// File: rtl/aec_report_fsm.sv
module aec_report_fsm
    import aec_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  fault_cause_e cause_in,
    output logic         rpt_valid,
    output logic         rpt_error,
    output logic [2:0]   rpt_cause
);

    rpt_state_e   state_q;
    rpt_state_e   state_d;
    fault_cause_e cause_q;
    fault_cause_e cause_d;
    logic         fault_now;

    always_comb begin
        fault_now = (cause_in != CAUSE_NONE);
    end

    always_comb begin
        state_d = ST_IDLE;
        cause_d = CAUSE_NONE;
        unique case (state_q)
            ST_IDLE, ST_PASS, ST_FAULT: begin
                if (req_valid && fault_now) begin
                    state_d = ST_FAULT;
                    cause_d = cause_in;
                end else if (req_valid) begin
                    state_d = ST_PASS;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        rpt_valid = 1'b0;
        rpt_error = 1'b0;
        rpt_cause = 3'd0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PASS: rpt_valid = 1'b1;
            ST_FAULT: begin
                rpt_valid = 1'b1;
                rpt_error = 1'b1;
                rpt_cause = cause_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/addr_err_checker.sv
module addr_err_checker
    import aec_pkg::*;
#(
    parameter int unsigned        ADDR_W       = 32,
    parameter logic [ADDR_W-1:0]  EXT_BASE     = 'h0010_0000,
    parameter logic [ADDR_W-1:0]  EXT_LIMIT    = 'hFFFF_7FFF,
    parameter logic [ADDR_W-1:0]  PERIPH_BASE  = 'hFFFF_8000,
    parameter logic [ADDR_W-1:0]  PERIPH_LIMIT = 'hFFFF_FFFF,
    parameter bit                 NARROW_EN    = 1'b1,
    parameter logic [ADDR_W-1:0]  NARROW_BASE  = 'hFFFF_8000,
    parameter logic [ADDR_W-1:0]  NARROW_LIMIT = 'hFFFF_83FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_kind,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] vbr,
    input  logic              single_chip,
    output logic              rpt_valid,
    output logic              rpt_error,
    output logic [2:0]        rpt_cause
);

    localparam int unsigned ALIGN_BITS = 2;

    region_hit_t  hit;
    fault_cause_e cause;
    logic         unused_vbr_hi;

    always_comb begin
        unused_vbr_hi = ^vbr[ADDR_W-1:ALIGN_BITS];
    end

    aec_region_decode #(
        .ADDR_W       (ADDR_W),
        .EXT_BASE     (EXT_BASE),
        .EXT_LIMIT    (EXT_LIMIT),
        .PERIPH_BASE  (PERIPH_BASE),
        .PERIPH_LIMIT (PERIPH_LIMIT),
        .NARROW_EN    (NARROW_EN),
        .NARROW_BASE  (NARROW_BASE),
        .NARROW_LIMIT (NARROW_LIMIT)
    ) u_decode (
        .addr (req_addr),
        .hit  (hit)
    );

    aec_rule_eval u_rules (
        .hit         (hit),
        .addr_lo     (req_addr[ALIGN_BITS-1:0]),
        .kind        (req_kind),
        .size        (req_size),
        .vbr_lo      (vbr[ALIGN_BITS-1:0]),
        .single_chip (single_chip),
        .cause       (cause)
    );

    aec_report_fsm u_report (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .cause_in  (cause),
        .rpt_valid (rpt_valid),
        .rpt_error (rpt_error),
        .rpt_cause (rpt_cause)
    );

endmodule

// File: rtl/aec_checker.sv
module aec_checker #(
    parameter int unsigned        ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]  EXT_BASE  = 'h0010_0000,
    parameter logic [ADDR_W-1:0]  EXT_LIMIT = 'hFFFF_7FFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [2:0]        req_kind,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] vbr,
    input logic              single_chip,
    input logic              rpt_valid,
    input logic              rpt_error,
    input logic [2:0]        rpt_cause
);

    logic req_in_ext;
    logic req_byte_data;

    always_comb begin
        req_in_ext    = (req_addr >= EXT_BASE) && (req_addr <= EXT_LIMIT);
        req_byte_data = ((req_kind == 3'd1) || (req_kind == 3'd2))
                      && (req_size == 2'd0);
    end

    // R11: a request yields a valid result in the next cycle
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rpt_valid);

    // R11: an empty cycle yields an all-zero result
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rpt_valid && !rpt_error && rpt_cause == 3'd0));

    // R11: the flag and a non-zero cause go together
    a_r11_flag_matches_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |-> (rpt_error == (rpt_cause != 3'd0)));

    // R1: an odd fetch is always some error
    a_r1_odd_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd0 && req_addr[0]) |=> rpt_error);

    // R3 and R10: mode violation wins over everything
    a_r3_mode_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && single_chip && req_in_ext) |=> (rpt_cause == 3'd1));

    // R8: a misaligned vector base always errors
    a_r8_vbr_align: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd4 && vbr[1:0] != 2'b00) |=> rpt_error);

    // R9: byte data outside a mode violation never errors
    a_r9_byte_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_byte_data && !(single_chip && req_in_ext)) |=> !rpt_error);

endmodule

bind addr_err_checker aec_checker #(
    .ADDR_W    (ADDR_W),
    .EXT_BASE  (EXT_BASE),
    .EXT_LIMIT (EXT_LIMIT)
) u_aec_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_kind    (req_kind),
    .req_size    (req_size),
    .vbr         (vbr),
    .single_chip (single_chip),
    .rpt_valid   (rpt_valid),
    .rpt_error   (rpt_error),
    .rpt_cause   (rpt_cause)
);

// File: tb/test_addr_err_checker.sv
`timescale 1ns/1ps
module test_addr_err_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_kind = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] vbr = '0;
    logic        single_chip = 1'b0;
    logic        rpt_valid;
    logic        rpt_error;
    logic [2:0]  rpt_cause;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    addr_err_checker i_addr_err_checker (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_kind    (req_kind),
        .req_size    (req_size),
        .vbr         (vbr),
        .single_chip (single_chip),
        .rpt_valid   (rpt_valid),
        .rpt_error   (rpt_error),
        .rpt_cause   (rpt_cause)
    );

    // {req[3:0], kind[2:0], size[1:0], single_chip, vbr_lo[1:0], addr[31:0], cause[2:0]}
    localparam int NV = 24;
    localparam logic [46:0] VEC [NV] = '{
        {4'd1,  3'd0, 2'd0, 1'b0, 2'd0, 32'h0000_1001, 3'd4}, // R1 odd fetch
        {4'd1,  3'd0, 2'd0, 1'b0, 2'd0, 32'h0000_1002, 3'd0}, // R1 even fetch
        {4'd2,  3'd0, 2'd1, 1'b0, 2'd0, 32'hFFFF_9000, 3'd2}, // R2 fetch periph
        {4'd2,  3'd1, 2'd1, 1'b0, 2'd0, 32'hFFFF_9000, 3'd0}, // R2 word read periph
        {4'd3,  3'd1, 2'd0, 1'b1, 2'd0, 32'h0020_0000, 3'd1}, // R3 byte read ext
        {4'd3,  3'd0, 2'd1, 1'b1, 2'd0, 32'h0020_0000, 3'd1}, // R3 fetch ext
        {4'd3,  3'd0, 2'd1, 1'b0, 2'd0, 32'h0020_0000, 3'd0}, // R3 expanded mode
        {4'd4,  3'd2, 2'd1, 1'b0, 2'd0, 32'h0000_2003, 3'd5}, // R4 odd word write
        {4'd4,  3'd1, 2'd1, 1'b0, 2'd0, 32'h0000_2002, 3'd0}, // R4 even word
        {4'd5,  3'd1, 2'd2, 1'b0, 2'd0, 32'h0000_2002, 3'd5}, // R5 long at 2
        {4'd5,  3'd2, 2'd2, 1'b0, 2'd0, 32'h0000_2004, 3'd0}, // R5 aligned long
        {4'd6,  3'd1, 2'd2, 1'b0, 2'd0, 32'hFFFF_8100, 3'd3}, // R6 long narrow
        {4'd6,  3'd1, 2'd1, 1'b0, 2'd0, 32'hFFFF_8100, 3'd0}, // R6 word narrow
        {4'd6,  3'd3, 2'd0, 1'b0, 2'd0, 32'hFFFF_8200, 3'd3}, // R6 stack narrow
        {4'd7,  3'd3, 2'd0, 1'b0, 2'd0, 32'h0000_3002, 3'd6}, // R7 stack mis
        {4'd7,  3'd3, 2'd0, 1'b0, 2'd0, 32'h0000_3004, 3'd0}, // R7 stack ok
        {4'd8,  3'd4, 2'd2, 1'b0, 2'd2, 32'h0000_0010, 3'd7}, // R8 vbr mis
        {4'd8,  3'd4, 2'd2, 1'b0, 2'd0, 32'h0000_0010, 3'd0}, // R8 vbr ok
        {4'd9,  3'd1, 2'd0, 1'b0, 2'd0, 32'h0000_4003, 3'd0}, // R9 byte odd
        {4'd9,  3'd2, 2'd0, 1'b0, 2'd0, 32'hFFFF_8101, 3'd0}, // R9 byte narrow
        {4'd10, 3'd0, 2'd0, 1'b1, 2'd0, 32'h0020_0001, 3'd1}, // R10 mode over odd
        {4'd10, 3'd1, 2'd2, 1'b0, 2'd0, 32'hFFFF_8102, 3'd3}, // R10 region over align
        {4'd10, 3'd0, 2'd0, 1'b0, 2'd0, 32'hFFFF_9001, 3'd2}, // R10 periph over odd
        {4'd10, 3'd3, 2'd0, 1'b1, 2'd0, 32'h0020_0002, 3'd1}  // R10 mode over stack
    };

    task automatic check3(input string tag, input logic v, input logic e,
                          input logic [2:0] c, input logic xv, input logic xe,
                          input logic [2:0] xc);
        n_checks++;
        if (v !== xv || e !== xe || c !== xc) begin
            n_fails++;
            $display("FAIL %s: got valid=%0b err=%0b cause=%0d, expected valid=%0b err=%0b cause=%0d",
                     tag, v, e, c, xv, xe, xc);
        end
    endtask

    task automatic drive(input logic [46:0] v);
        req_valid   = 1'b1;
        req_kind    = v[42:40];
        req_size    = v[39:38];
        single_chip = v[37];
        vbr         = {30'h0000_0400, v[36:35]};
        req_addr    = v[34:3];
    endtask

    initial begin
        // R12: outputs quiet during reset
        repeat (3) @(negedge clk);
        check3("R12 in reset", rpt_valid, rpt_error, rpt_cause, 1'b0, 1'b0, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check3("R12 after release", rpt_valid, rpt_error, rpt_cause, 1'b0, 1'b0, 3'd0);

        // Table walk, back to back
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check3($sformatf("vector %0d R%0d", i, VEC[i][46:43]),
                   rpt_valid, rpt_error, rpt_cause,
                   1'b1, VEC[i][2:0] != 3'd0, VEC[i][2:0]);
        end

        // R11: fault followed immediately by clean request
        drive(VEC[7]);
        @(negedge clk);
        drive(VEC[8]);
        @(negedge clk);
        check3("R11 fault then pass", rpt_valid, rpt_error, rpt_cause, 1'b1, 1'b0, 3'd0);

        // R11: empty cycle after a fault clears the result
        drive(VEC[0]);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check3("R11 idle after fault", rpt_valid, rpt_error, rpt_cause, 1'b0, 1'b0, 3'd0);

        // R11: faulting inputs without valid report nothing
        req_kind = 3'd0; req_addr = 32'h0000_0001; req_valid = 1'b0;
        @(negedge clk);
        check3("R11 no valid no report", rpt_valid, rpt_error, rpt_cause, 1'b0, 1'b0, 3'd0);

        // R5: reserved kind 5 behaves as data read
        req_valid = 1'b1; req_kind = 3'd5; req_size = 2'd2;
        single_chip = 1'b0; req_addr = 32'h0000_5001; vbr = '0;
        @(negedge clk);
        check3("R5 reserved kind as read", rpt_valid, rpt_error, rpt_cause, 1'b1, 1'b1, 3'd5);

        // R12: reset while a fault is held
        drive(VEC[16]);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check3("R12 reset mid fault", rpt_valid, rpt_error, rpt_cause, 1'b0, 1'b0, 3'd0);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule